// File: doc/BRIEF.md
# DRAM Strobe and Refresh Decoder

This block is the control logic of an extended-data-out DRAM device, seen from inside the device. It samples the active-low row strobe, column strobe, write enable and output enable on a fast internal clock and finds their edges from registered copies. Each falling edge of the row strobe is classified by what the column strobe and the held read state look like at that moment. There are three classes: an externally addressed row cycle (a normal access or a row-strobe-only refresh), a column-before-row refresh, or a hidden refresh.

For every row cycle the block emits a one-cycle refresh strobe, the cycle class and the row to open. The row comes from the address pins for externally addressed cycles and from an internal wrapping counter for the two internally addressed refresh kinds. The block also produces the data-output enable. That enable follows the extended-data-out hold rule: read data stays driven after the column strobe rises, and stops only when both strobes are high. Write enable and output enable can force it off, and each refresh kind applies its own rule to it. The storage array itself is outside the block.

Top module: `dram_ctl_decoder`

## Requirements
- R1: After reset, dq_oe_o and rfsh_o are 0, cyc_o is 0 (no cycle) and row_o is 0.
- R2: A row strobe fall while the column strobe is high gives a one-cycle rfsh_o pulse with cyc_o = 1 (external row) and row_o equal to the address present at that fall. Such a cycle without a column strobe leaves dq_oe_o at 0.
- R3: A row strobe fall while the column strobe is already low, and no read data is held, gives rfsh_o with cyc_o = 2 (column-before-row refresh) and row_o equal to the internal counter. dq_oe_o is 0 whatever we_ni and oe_ni are.
- R4: A row strobe fall while the column strobe stays low and read data is held from an earlier read gives rfsh_o with cyc_o = 3 (hidden refresh) and row_o equal to the internal counter. dq_oe_o stays 1 throughout.
- R5: The internal counter starts at 0 after reset. It advances by one, modulo 2^ROW_W (ROW_W = 12 by default, 11 for the small variant), after every cyc_o = 2 or 3 cycle, and does not move on cyc_o = 1 cycles.
- R6: A column strobe fall while the row strobe is low and we_ni is high starts a read. dq_oe_o then goes to 1 while oe_ni is low.
- R7: Read data stays driven after the column strobe rises. dq_oe_o goes to 0 only once both strobes are high, whichever of the two rises last.
- R8: we_ni low or oe_ni high holds dq_oe_o at 0. A column strobe fall with we_ni low (a write) ends any held read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fast internal sampling clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| ras_ni | input | 1 | row strobe, active low, asynchronous |
| cas_ni | input | 1 | column strobe, active low, asynchronous |
| we_ni | input | 1 | write enable, active low |
| oe_ni | input | 1 | output enable, active low |
| addr_i | input | ROW_W | multiplexed address pins |
| rfsh_o | output | 1 | one-cycle pulse: open and refresh row_o |
| cyc_o | output | 2 | class of the last row cycle (0 none, 1 external row, 2 column-before-row, 3 hidden) |
| row_o | output | ROW_W | row opened by the last row cycle |
| dq_oe_o | output | 1 | data-output drive enable |

## Verification
The bench goes after the ordering cases. A column strobe that is already low when the row strobe falls must give a column-before-row refresh if no read is held, but a hidden refresh if a read is held. A decoder that mixes these up uses the wrong row or cuts the output in the middle of a hidden refresh. It also covers the row strobe rising before the column strobe and the reverse order. A design that tied the output to the column strobe alone would release the data too early or hold it too long. It drives thousands of internal refreshes so that the counter wraps, with random write and output enables during them, which would expose a counter that saturates or a refresh that listens to those pins.

// File: rtl/dramdec_pkg.sv
package dramdec_pkg;
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_EXT  = 2'd1,
    CYC_CBR  = 2'd2,
    CYC_HID  = 2'd3
  } cyc_e;
endpackage

// File: rtl/dramdec_sync.sv
module dramdec_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= {W{RST_V}};
    else         st_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[i] <= {W{RST_V}};
      else         st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dramdec_rcnt.sv
module dramdec_rcnt #(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;  // natural wrap
  end
endmodule

// File: rtl/dramdec_doe.sv
module dramdec_doe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_s_i,
  input  logic cas_s_i,
  input  logic we_s_i,
  input  logic oe_s_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic cbr_i,
  output logic drv_o,
  output logic dq_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                drv_o <= 1'b0;
    else if (ras_s_i & cas_s_i) drv_o <= 1'b0;  // last strobe up
    else if (cbr_i | wr_i)      drv_o <= 1'b0;
    else if (rd_i)              drv_o <= 1'b1;
  end

  assign dq_oe_o = drv_o & we_s_i & ~oe_s_i;
endmodule

// File: rtl/dram_ctl_decoder.sv
module dram_ctl_decoder
  import dramdec_pkg::*;
#(
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic             oe_ni,
  input  logic [ROW_W-1:0] addr_i,
  output logic             rfsh_o,
  output logic [1:0]       cyc_o,
  output logic [ROW_W-1:0] row_o,
  output logic             dq_oe_o
);
  localparam int unsigned CTL_W = 4;

  logic [CTL_W-1:0] ctl_s;
  logic [ROW_W-1:0] addr_s;
  logic ras_s, cas_s, we_s, oe_s;
  logic ras_q, cas_q;
  logic ras_fall, cas_fall;
  logic drv;
  logic [ROW_W-1:0] ctr;
  cyc_e kind_d;

  dramdec_sync #(.W(CTL_W), .STAGES(STAGES), .RST_V(1'b1)) u_sync_ctl (
    .clk_i, .rst_ni, .d_i({ras_ni, cas_ni, we_ni, oe_ni}), .q_o(ctl_s)
  );
  dramdec_sync #(.W(ROW_W), .STAGES(STAGES), .RST_V(1'b0)) u_sync_adr (
    .clk_i, .rst_ni, .d_i(addr_i), .q_o(addr_s)
  );
  assign {ras_s, cas_s, we_s, oe_s} = ctl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      ras_q <= ras_s;
      cas_q <= cas_s;
    end
  end

  assign ras_fall = ras_q & ~ras_s;
  assign cas_fall = cas_q & ~cas_s;

  // column strobe already low at row fall: hidden if read data held
  always_comb begin
    if (cas_s)    kind_d = CYC_EXT;
    else if (drv) kind_d = CYC_HID;
    else          kind_d = CYC_CBR;
  end

  dramdec_rcnt #(.ROW_W(ROW_W)) u_rcnt (
    .clk_i, .rst_ni,
    .inc_i(ras_fall & (kind_d != CYC_EXT)),
    .cnt_o(ctr)
  );

  dramdec_doe u_doe (
    .clk_i, .rst_ni,
    .ras_s_i(ras_s), .cas_s_i(cas_s), .we_s_i(we_s), .oe_s_i(oe_s),
    .rd_i(cas_fall & ~ras_s & we_s),
    .wr_i(cas_fall & ~ras_s & ~we_s),
    .cbr_i(ras_fall & (kind_d == CYC_CBR)),
    .drv_o(drv),
    .dq_oe_o(dq_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rfsh_o <= 1'b0;
      cyc_o  <= CYC_NONE;
      row_o  <= '0;
    end else begin
      rfsh_o <= ras_fall;
      if (ras_fall) begin
        cyc_o <= kind_d;
        row_o <= (kind_d == CYC_EXT) ? addr_s : ctr;
      end
    end
  end
endmodule

// File: rtl/dramdec_chk.sv
module dramdec_chk #(
  parameter int unsigned ROW_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rfsh_i,
  input logic [1:0]       cyc_i,
  input logic [ROW_W-1:0] row_i,
  input logic [ROW_W-1:0] ctr_i,
  input logic             dq_oe_i,
  input logic             ras_s_i,
  input logic             cas_s_i,
  input logic             drv_i
);
  // R2
  ext_row_z_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_i && cyc_i == 2'd1) |-> !dq_oe_i);
  // R3
  cbr_z_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_i && cyc_i == 2'd2) |-> !dq_oe_i);
  // R5
  ctr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_i && cyc_i[1]) |-> ctr_i == ROW_W'(row_i + 1'b1));
  // R7
  both_high_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_s_i && cas_s_i) |=> !drv_i);
  // R2
  pulse_cls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_i |-> cyc_i != 2'd0);
endmodule

bind dram_ctl_decoder dramdec_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rfsh_i(rfsh_o), .cyc_i(cyc_o),
  .row_i(row_o), .ctr_i(ctr), .dq_oe_i(dq_oe_o),
  .ras_s_i(ras_s), .cas_s_i(cas_s), .drv_i(drv)
);

// File: tb/tb_dram_ctl_decoder.sv
module tb_dram_ctl_decoder;
  localparam int unsigned ROW_W = 12;
  localparam int unsigned ROWS  = 1 << ROW_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [ROW_W-1:0] addr = '0;
  logic rfsh;
  logic [1:0] cyc;
  logic [ROW_W-1:0] row;
  logic dq_oe;

  int total = 0, bad = 0;
  int pulses = 0, last_cyc = 0, last_row = 0;
  int m_pulses = 0, m_cyc = 0, m_row = 0, m_ctr = 0;
  bit m_drv = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_ctl_decoder #(.ROW_W(ROW_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr),
    .rfsh_o(rfsh), .cyc_o(cyc), .row_o(row), .dq_oe_o(dq_oe)
  );

  always @(negedge clk) if (rst_n && rfsh) begin
    pulses++;
    last_cyc = int'(cyc);
    last_row = int'(row);
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_kind(bit c, bit drv);
    if (c) return 1;
    return drv ? 3 : 2;
  endfunction

  function automatic bit exp_oe(bit drv, bit w, bit o);
    return drv & w & ~o;
  endfunction

  // drive one pin state, let it settle, then compare with the model
  task automatic step(string tag, bit r, bit c, bit w, bit o, int a);
    bit pr, pc;
    pr = ras_n; pc = cas_n;
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = ROW_W'(a);
    if (pr && !r) begin
      m_pulses++;
      m_cyc = exp_kind(c, m_drv);
      if (m_cyc == 1) m_row = a;
      else begin
        m_row = m_ctr;
        m_ctr = (m_ctr + 1) % ROWS;
      end
      if (m_cyc == 2) m_drv = 0;
    end
    if (r && c) m_drv = 0;
    else if (pc && !c && !r) m_drv = w;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check({tag, " pulses"}, pulses, m_pulses);
    check({tag, " cyc"}, last_cyc, m_cyc);
    check({tag, " row"}, last_row, m_row);
    check({tag, " dq_oe"}, int'(dq_oe), int'(exp_oe(m_drv, w, o)));
  endtask

  task automatic idle(string tag);
    step(tag, 1, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 dq_oe", int'(dq_oe), 0);
    check("R1 rfsh", int'(rfsh), 0);
    check("R1 cyc", int'(cyc), 0);
    check("R1 row", int'(row), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 read then R7 column rises first
    step("R2 ext row", 0, 1, 1, 0, 12'h5a3);
    step("R6 read", 0, 0, 1, 0, 12'h5a3);
    step("R7 cas up hold", 0, 1, 1, 0, 0);
    step("R8 oe high", 0, 1, 1, 1, 0);
    step("R8 oe back", 0, 1, 1, 0, 0);
    step("R8 we low", 0, 1, 0, 0, 0);
    step("R7 ras up last", 1, 1, 1, 0, 0);

    // R2 row-only refresh
    step("R2 ror", 0, 1, 1, 0, 12'hfff);
    idle("R2 ror end");

    // R3 CBR with enables that would otherwise drive
    step("R3 cas first", 1, 0, 1, 0, 0);
    step("R3 cbr", 0, 0, 1, 0, 0);
    step("R3 cbr we", 0, 0, 0, 1, 0);
    idle("R3 end");

    // R4 hidden: read, ras toggles with cas held, then R7 ras rises first
    step("R4 act", 0, 1, 1, 0, 12'h012);
    step("R4 read", 0, 0, 1, 0, 12'h012);
    step("R7 ras up first", 1, 0, 1, 0, 0);
    step("R4 hidden", 0, 0, 1, 0, 0);
    step("R4 ras up", 1, 0, 1, 0, 0);
    step("R4 hidden2", 0, 0, 1, 0, 0);
    step("R4 ras up2", 1, 0, 1, 0, 0);
    step("R7 cas up last", 1, 1, 1, 0, 0);

    // R8 write ends held data
    step("R8 act", 0, 1, 1, 0, 12'h777);
    step("R8 read", 0, 0, 1, 0, 0);
    step("R8 cas up", 0, 1, 1, 0, 0);
    step("R8 write", 0, 0, 0, 0, 0);
    step("R8 we back", 0, 0, 1, 0, 0);
    idle("R8 end");

    // random mix
    void'($urandom(32'd4711));
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 3);
      int a = $urandom_range(0, ROWS - 1);
      bit w = 1'($urandom);
      bit o = 1'($urandom);
      case (op)
        0: begin
          step("R6 rnd act", 0, 1, 1, 0, a);
          step("R6 rnd col", 0, 0, w, o, a);
          step("R7 rnd cas up", 0, 1, w, o, a);
          idle("R7 rnd end");
        end
        1: begin
          step("R2 rnd ror", 0, 1, w, o, a);
          idle("R2 rnd end");
        end
        2: begin
          step("R3 rnd cas", 1, 0, w, o, a);
          step("R3 rnd cbr", 0, 0, w, o, a);
          idle("R3 rnd end");
        end
        default: begin
          step("R4 rnd act", 0, 1, 1, 0, a);
          step("R4 rnd read", 0, 0, 1, 0, a);
          step("R4 rnd ras up", 1, 0, 1, o, a);
          step("R4 rnd hid", 0, 0, 1, o, a);
          step("R4 rnd ras up2", 1, 0, 1, o, a);
          idle("R4 rnd end");
        end
      endcase
    end

    // R5 drive the counter through a full wrap
    for (int i = 0; i < ROWS + 2; i++) begin
      bit w = 1'($urandom);
      bit o = 1'($urandom);
      step("R5 wrap cas", 1, 0, w, o, 0);
      step("R5 wrap cbr", 0, 0, w, o, 0);
      idle("R5 wrap end");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (195000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule